// File: doc/BRIEF.md
# Per-Source Trigger Interrupt Controller

This block gathers 32 asynchronous interrupt inputs into a single interrupt request for a processor. Software chooses, separately for every input, whether it is sensed by level or by edge, and which polarity counts as active. Each input first passes through a two-flop synchroniser. A detected event then sets a per-source pending latch. The latch holds until software writes a one to that source's bit in the clear register.

A simple single-cycle bus gives access to the registers: valid, write, a 12-bit byte address, 32-bit write data, and read data that is valid in the same cycle as valid. The status register shows the pending bits masked by the enable register. The request output is a registered OR of the status bits. A level source that is cleared while still active latches again at once, so software can clear such a source and then fix its cause in either order.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable register (offset 0x04) reads 0, the mode register (0x0C) reads 0, the polarity register (0x10) reads 0xFFFFFFFF, status (0x00) reads 0 and irq_o is 0.
- R2: Enable, mode and polarity read back the last value written. The clear register (0x08) and any unmapped offset read 0. A write to status (0x00) changes nothing.
- R3: Status bit n equals pending bit n AND enable bit n. A disabled source still latches, and it shows in status once it is enabled.
- R4: Writing a 1 to bit n of the clear register (0x08) drops pending bit n. Writing a 0 leaves that bit unchanged. Pending bits hold while not cleared.
- R5: When mode bit n is 0 the source is level sensed. Polarity bit 0 means an input high is active; polarity bit 1 means an input low is active. An active input sets the pending bit.
- R6: When mode bit n is 1 the source is edge sensed. Polarity bit 0 selects the rising edge and polarity bit 1 selects the falling edge. The other edge does nothing, and an input held at a steady value after a clear does not latch again.
- R7: A level source that is cleared while its input is still active is pending again in the next cycle.
- R8: An input change sets its pending bit at the third rising clock edge after it is applied. If the clear write for that bit is captured at the same edge, the bit stays pending.
- R9: irq_o equals the OR of all status bits as they were one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | Asynchronous interrupt inputs, one per source |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address inside the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bound checker checks four things on every cycle: the registered request follows the previous status, a detected event always reaches its pending bit, a pending bit without a clear never drops, and a cleared bit with no new event is gone. It also checks that status reads never show a disabled source and that the clear offset reads as zero. Only the bench scenarios can show how the mode and polarity settings map to edges and levels, the re-latch of a held level source, the exact synchroniser latency, and the same-edge race between an event and a clear, because these need chosen input waveforms and bus writes at known cycles.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Byte offsets of the register window
  localparam int unsigned OFS_STATUS = 32'h00;
  localparam int unsigned OFS_ENABLE = 32'h04;
  localparam int unsigned OFS_CLEAR  = 32'h08;
  localparam int unsigned OFS_MODE   = 32'h0C;
  localparam int unsigned OFS_POL    = 32'h10;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CLEAR,
    SEL_MODE,
    SEL_POL,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] st_d [STAGES];

  always_comb begin
    st_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  assign prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic active;
    logic rise;
    logic fall;
    assign active   = lvl_i[b] ^ pol_i[b];
    assign rise     = lvl_i[b] & ~prev_q[b];
    assign fall     = ~lvl_i[b] & prev_q[b];
    assign evt_o[b] = mode_i[b] ? (pol_i[b] ? fall : rise) : active;
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  // A new event outranks a clear in the same cycle
  assign pend_d = (pend_q & ~clr_i) | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      en_o,
  output logic [W-1:0]      mode_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      clr_o
);
  reg_sel_e     sel;
  logic         wr;
  logic         en_we, mode_we, pol_we;
  logic [W-1:0] en_q, mode_q, pol_q;
  logic [W-1:0] en_d, mode_d, pol_d;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
    else if (bus_addr == ADDR_W'(OFS_CLEAR))  sel = SEL_CLEAR;
    else if (bus_addr == ADDR_W'(OFS_MODE))   sel = SEL_MODE;
    else if (bus_addr == ADDR_W'(OFS_POL))    sel = SEL_POL;
    else                                      sel = SEL_NONE;
  end

  assign wr      = bus_valid & bus_write;
  assign en_we   = wr & (sel == SEL_ENABLE);
  assign mode_we = wr & (sel == SEL_MODE);
  assign pol_we  = wr & (sel == SEL_POL);
  assign clr_o   = (wr & (sel == SEL_CLEAR)) ? bus_wdata : '0;

  assign en_d   = bus_wdata;
  assign mode_d = bus_wdata;
  assign pol_d  = bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '1;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (mode_we) mode_q <= mode_d;
      if (pol_we)  pol_q  <= pol_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      unique case (sel)
        SEL_STATUS: bus_rdata = pend_i & en_q;
        SEL_ENABLE: bus_rdata = en_q;
        SEL_MODE:   bus_rdata = mode_q;
        SEL_POL:    bus_rdata = pol_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NSRC        = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq_o
);
  logic [1:0]      rs_q;
  logic            rst_int_n;
  logic [NSRC-1:0] lvl, evt, pend_q, clr, en_q, mode_q, pol_q;
  logic            irq_q, irq_d;

  // Reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  irqc_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(src_i), .q_o(lvl)
  );

  irqc_detect #(.W(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_int_n), .lvl_i(lvl), .mode_i(mode_q),
    .pol_i(pol_q), .evt_o(evt)
  );

  irqc_pending #(.W(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_int_n), .evt_i(evt), .clr_i(clr), .pend_o(pend_q)
  );

  irqc_regs #(.W(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pend_i(pend_q), .en_o(en_q), .mode_o(mode_q),
    .pol_o(pol_q), .clr_o(clr)
  );

  assign irq_d = |(pend_q & en_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NSRC-1:0]   bus_rdata,
  input logic              irq_o,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   pend_q,
  input logic [NSRC-1:0]   evt,
  input logic [NSRC-1:0]   clr
);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(pend_q & en_q)));

  p_status_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == '0) |-> ((bus_rdata & ~en_q) == '0));

  p_clear_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(8)) |-> (bus_rdata == '0));

  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  p_pend_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0) |=> (($past(pend_q & ~clr) & ~pend_q) == '0));

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((pend_q & $past(clr & ~evt)) == '0));
endmodule

bind irqc_top irqc_checker #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_o(irq_o), .en_q(en_q),
  .pend_q(pend_q), .evt(evt), .clr(clr)
);

// File: tb/irqc_top_test.sv
module irqc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic        mon_req = 1'b0;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Monitor: samples 3 ns after the falling edge, well before the next rise
  always @(negedge clk) begin
    #3;
    if (mon_req) begin
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL monitor: request with empty queue");
      end else begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq_o} : bus_rdata;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; mon_req = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {31'd0, exp}; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd(12'h004, 32'h0, "R1 enable reset");
    rd(12'h00C, 32'h0, "R1 mode reset");
    rd(12'h010, 32'hFFFF_FFFF, "R1 polarity reset");
    rd(12'h000, 32'h0, "R1 status reset");
    chk_irq(1'b0, "R1 irq reset");
    // R2 map
    rd(12'h008, 32'h0, "R2 clear reads zero");
    rd(12'h100, 32'h0, "R2 unmapped reads zero");
    wr(12'h010, 32'h0);
    wr(12'h008, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, 32'hFFFF_FFFF, "R2 enable readback");
    rd(12'h010, 32'h0, "R2 polarity readback");
    rd(12'h000, 32'h0, "R3 status idle");
    idle(2);
    chk_irq(1'b0, "R9 irq idle");
    // R5 active-high level, R7 relatch
    src[3] = 1'b1; idle(5);
    rd(12'h000, 32'h0000_0008, "R5 level high pending");
    chk_irq(1'b1, "R9 irq raised");
    wr(12'h008, 32'h0000_0008);
    rd(12'h000, 32'h0000_0008, "R7 relatch while active");
    src[3] = 1'b0; idle(5);
    wr(12'h008, 32'h0000_0008);
    rd(12'h000, 32'h0, "R4 clear after release");
    idle(2);
    chk_irq(1'b0, "R9 irq dropped");
    // R6 rising edge
    wr(12'h00C, 32'h0000_0020);
    src[5] = 1'b1; idle(5);
    rd(12'h000, 32'h0000_0020, "R6 rising edge pending");
    wr(12'h008, 32'hFFFF_FFDF);
    rd(12'h000, 32'h0000_0020, "R4 zero bits no effect");
    wr(12'h000, 32'h0);
    rd(12'h000, 32'h0000_0020, "R2 status write ignored");
    wr(12'h008, 32'h0000_0020); idle(3);
    rd(12'h000, 32'h0, "R6 held input no relatch");
    src[5] = 1'b0; idle(5);
    rd(12'h000, 32'h0, "R6 falling ignored in rising mode");
    // R6 falling edge on source 7
    src[7] = 1'b1; idle(5);
    wr(12'h00C, 32'h0000_00A0);
    wr(12'h010, 32'h0000_0080);
    wr(12'h008, 32'h0000_0080);
    rd(12'h000, 32'h0, "R6 falling mode quiet");
    rd(12'h00C, 32'h0000_00A0, "R2 mode readback");
    src[7] = 1'b0; idle(5);
    rd(12'h000, 32'h0000_0080, "R6 falling edge pending");
    wr(12'h008, 32'h0000_0080);
    src[7] = 1'b1; idle(5);
    rd(12'h000, 32'h0, "R6 rising ignored in falling mode");
    // R5 active-low level on source 10
    src[10] = 1'b1; idle(5);
    wr(12'h010, 32'h0000_0480);
    wr(12'h008, 32'h0000_0400);
    rd(12'h000, 32'h0, "R5 active-low inactive when high");
    src[10] = 1'b0; idle(5);
    rd(12'h000, 32'h0000_0400, "R5 active-low pending when low");
    wr(12'h010, 32'h0000_0080);
    wr(12'h008, 32'h0000_0400);
    rd(12'h000, 32'h0, "R5 cleared after polarity change");
    // R3 masking
    wr(12'h004, 32'hFFFF_EFFF);
    src[12] = 1'b1; idle(5);
    rd(12'h000, 32'h0, "R3 disabled source hidden");
    chk_irq(1'b0, "R3 disabled source no irq");
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0000_1000, "R3 latched while disabled");
    src[12] = 1'b0; idle(5);
    wr(12'h008, 32'h0000_1000);
    rd(12'h000, 32'h0, "R4 clear source 12");
    // R8 latency: set at third edge after the change
    wr(12'h00C, 32'h0000_02A0);
    @(negedge clk); src[5] = 1'b1;
    rd(12'h000, 32'h0, "R8 not yet pending after one edge");
    rd(12'h000, 32'h0000_0020, "R8 pending after third edge");
    wr(12'h008, 32'h0000_0020);
    // R8 event and clear captured at the same edge
    @(negedge clk); src[9] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h008; bus_wdata = 32'h0000_0200;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    rd(12'h000, 32'h0000_0200, "R8 event beats clear");
    wr(12'h008, 32'h0000_0200);
    rd(12'h000, 32'h0, "R8 later clear drops bit");
    idle(2);
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule